// File: doc/BRIEF.md
# Banked buffer window translator

The block sits between a host that sees only a small fixed window of bytes and a larger on-board buffer RAM reached through that window. The host issues a request made of a buffer base address and a 16-bit word offset. Because the data path is 16 bits wide, the byte address is the base plus twice the word offset. The block splits that byte address into a bank number and an offset inside the window. The bank is the byte address with its low window bits dropped. The offset is those low bits.

The block keeps the bank that is currently mapped. A bank-select register write leaves the block only when a request needs a different bank, and the mapped bank is then updated. Requests that stay in the mapped bank cost no register write and return a cycle sooner. After reset the mapped bank is unknown, so the first request always writes.

A configuration request checks a proposed window base against a fixed pattern. An accepted base maps bank 0 and makes it the current bank. A rejected base is reported and leaves the mapping untouched.

Top module: `bank_window_xlate`

## Requirements
- R1: The byte address is `reqBase + 2*reqOffset`, taken modulo 2^ADDR_W (20 bits by default), so it wraps at the top of the buffer.
- R2: The bank number is the byte address shifted right by WOFF_BITS (13, giving 8 KB banks). A bank write carries the bank number in `bankWrData[BANK_W-1:0]` and a set select-enable bit in `bankWrData[BANK_W]`.
- R3: `rspOffset` equals the byte address masked to the low WOFF_BITS bits, valid while `rspValid` is high.
- R4: When a request needs a bank other than the mapped one, `bankWrEn` pulses for one cycle, on the cycle after the request is accepted, and `rspValid` follows on the next cycle. When the bank is already mapped, `rspValid` rises on the cycle after acceptance and no bank write occurs.
- R5: After reset no bank counts as mapped, so the first request writes the bank register even when it targets bank 0.
- R6: A configuration base is accepted when `(cfgBase & 0x1E000) ^ cfgBase == 0xC0000`, that is when it equals 0xC0000 once bits 13 to 16 are cleared. On acceptance, on the cycle after `cfgValid` is taken, `cfgDone` pulses together with a bank write of bank 0 with the enable bit set, and later requests to bank 0 need no write.
- R7: Any other configuration base pulses `cfgBad` on the cycle after `cfgValid` is taken, issues no bank write and leaves the mapped bank unchanged.
- R8: `rspAlignErr` is high with `rspValid` exactly when `rspOffset` is odd.
- R9: `reqReady` is high only while the block is idle and `cfgValid` is low. A configuration request offered together with a host request is served first.
- R10: After reset `reqReady` is high and `rspValid`, `bankWrEn`, `cfgDone` and `cfgBad` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Configuration request, taken in one cycle while idle |
| cfgBase | input | CFG_W | Proposed window base address |
| cfgDone | output | 1 | Configuration accepted, bank 0 mapped |
| cfgBad | output | 1 | Configuration base rejected |
| reqValid | input | 1 | Host translation request |
| reqReady | output | 1 | Request accepted on this edge when high with reqValid |
| reqBase | input | ADDR_W | Buffer base byte address |
| reqOffset | input | OFF_W | Offset in 16-bit words |
| rspValid | output | 1 | Translated offset present (one-cycle pulse) |
| rspOffset | output | WOFF_BITS | Byte offset inside the window |
| rspAlignErr | output | 1 | Translated offset is odd |
| bankWrEn | output | 1 | Bank-select register write strobe |
| bankWrData | output | BANK_W+1 | Enable bit over bank number |

## Verification
The assertions take for granted that the response side always accepts `rspValid` in its single cycle, because there is no backpressure. They also assume that `cfgBase`, `reqBase` and `reqOffset` are valid in the cycle their strobe is taken. The stimulus drives every input on the falling edge. It raises a request only after the previous response or configuration pulse has ended, and it holds address fields only for the accepting cycle. This keeps the write-then-respond ordering that the checker follows free of overlapping transactions.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_RESPOND,
    ST_CFGWR,
    ST_CFGREJ
  } bwtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;     // capture translated request
    logic commitBank;  // mapped bank <= requested bank
    logic cfgBankZero; // mapped bank <= 0, write data selects bank 0
  } bwtStrobe_t;

endpackage

// File: rtl/bwt_datapath.sv
module bwt_datapath
  import bwt_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int OFF_W     = 16,
  parameter int WOFF_BITS = 13,
  parameter int CFG_W     = 20,
  parameter logic [CFG_W-1:0] CFG_MASK  = 20'h1E000,
  parameter logic [CFG_W-1:0] CFG_MATCH = 20'hC0000,
  localparam int BANK_W   = ADDR_W - WOFF_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bwtStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    reqBase,
  input  logic [OFF_W-1:0]     reqOffset,
  input  logic [CFG_W-1:0]     cfgBase,
  output logic                 bankHit,
  output logic                 cfgBaseOk,
  output logic [BANK_W:0]      bankWrData,
  output logic [WOFF_BITS-1:0] rspOffset,
  output logic                 rspAlignErr
);

  logic [ADDR_W-1:0]    byteOff;
  logic [ADDR_W-1:0]    linearAddr;
  logic [BANK_W-1:0]    reqBank;
  logic [WOFF_BITS-1:0] reqWinOff;
  logic [BANK_W-1:0]    curBank;
  logic                 curValid;

  // word offset scaled for the 16-bit data path
  assign byteOff    = ADDR_W'({reqOffset, 1'b0});
  assign linearAddr = reqBase + byteOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBank   <= '0;
      reqWinOff <= '0;
    end else if (strobe.loadReq) begin
      reqBank   <= linearAddr[ADDR_W-1:WOFF_BITS];
      reqWinOff <= linearAddr[WOFF_BITS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBank  <= '0;
      curValid <= 1'b0;
    end else if (strobe.cfgBankZero) begin
      curBank  <= '0;
      curValid <= 1'b1;
    end else if (strobe.commitBank) begin
      curBank  <= reqBank;
      curValid <= 1'b1;
    end
  end

  assign bankHit     = curValid && (curBank == reqBank);
  assign cfgBaseOk   = (cfgBase & ~CFG_MASK) == CFG_MATCH;
  assign bankWrData  = {1'b1, strobe.cfgBankZero ? {BANK_W{1'b0}} : reqBank};
  assign rspOffset   = reqWinOff;
  assign rspAlignErr = reqWinOff[0];

endmodule

// File: rtl/bwt_control.sv
module bwt_control
  import bwt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       cfgValid,
  input  logic       bankHit,
  input  logic       cfgBaseOk,
  output logic       reqReady,
  output logic       rspValid,
  output logic       bankWrEn,
  output logic       cfgDone,
  output logic       cfgBad,
  output bwtStrobe_t strobe
);

  bwtState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    reqReady  = 1'b0;
    rspValid  = 1'b0;
    bankWrEn  = 1'b0;
    cfgDone   = 1'b0;
    cfgBad    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = !cfgValid;
        if (cfgValid) begin
          nextState = cfgBaseOk ? ST_CFGWR : ST_CFGREJ;
        end else if (reqValid) begin
          strobe.loadReq = 1'b1;
          nextState      = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (bankHit) begin
          rspValid  = 1'b1;
          nextState = ST_IDLE;
        end else begin
          bankWrEn          = 1'b1;
          strobe.commitBank = 1'b1;
          nextState         = ST_RESPOND;
        end
      end
      ST_RESPOND: begin
        rspValid  = 1'b1;
        nextState = ST_IDLE;
      end
      ST_CFGWR: begin
        bankWrEn           = 1'b1;
        cfgDone            = 1'b1;
        strobe.cfgBankZero = 1'b1;
        nextState          = ST_IDLE;
      end
      ST_CFGREJ: begin
        cfgBad    = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/bank_window_xlate.sv
module bank_window_xlate
  import bwt_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int OFF_W     = 16,
  parameter int WOFF_BITS = 13,
  parameter int CFG_W     = 20,
  parameter logic [CFG_W-1:0] CFG_MASK  = 20'h1E000,
  parameter logic [CFG_W-1:0] CFG_MATCH = 20'hC0000,
  localparam int BANK_W   = ADDR_W - WOFF_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgValid,
  input  logic [CFG_W-1:0]     cfgBase,
  output logic                 cfgDone,
  output logic                 cfgBad,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [ADDR_W-1:0]    reqBase,
  input  logic [OFF_W-1:0]     reqOffset,
  output logic                 rspValid,
  output logic [WOFF_BITS-1:0] rspOffset,
  output logic                 rspAlignErr,
  output logic                 bankWrEn,
  output logic [BANK_W:0]      bankWrData
);

  bwtStrobe_t strobe;
  logic       bankHit;
  logic       cfgBaseOk;

  bwt_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cfgValid (cfgValid),
    .bankHit  (bankHit),
    .cfgBaseOk(cfgBaseOk),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .bankWrEn (bankWrEn),
    .cfgDone  (cfgDone),
    .cfgBad   (cfgBad),
    .strobe   (strobe)
  );

  bwt_datapath #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .WOFF_BITS(WOFF_BITS),
    .CFG_W    (CFG_W),
    .CFG_MASK (CFG_MASK),
    .CFG_MATCH(CFG_MATCH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqBase    (reqBase),
    .reqOffset  (reqOffset),
    .cfgBase    (cfgBase),
    .bankHit    (bankHit),
    .cfgBaseOk  (cfgBaseOk),
    .bankWrData (bankWrData),
    .rspOffset  (rspOffset),
    .rspAlignErr(rspAlignErr)
  );

endmodule

// File: rtl/bank_window_xlate_chk.sv
module bank_window_xlate_chk #(
  parameter int BANK_W = 7
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            rspValid,
  input logic            bankWrEn,
  input logic [BANK_W:0] bankWrData,
  input logic            cfgDone,
  input logic            cfgBad
);

  logic wrSeen;

  always_ff @(posedge clk) begin
    if (!rstN)         wrSeen <= 1'b0;
    else if (bankWrEn) wrSeen <= 1'b1;
  end

  // R2
  wr_enable_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    bankWrEn |-> bankWrData[BANK_W]);

  // R4
  miss_then_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankWrEn && !cfgDone) |=> rspValid);

  // R4
  rsp_no_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !bankWrEn);

  // R5
  first_rsp_after_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> wrSeen);

  // R6
  cfg_done_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |-> (bankWrEn && bankWrData == {1'b1, {BANK_W{1'b0}}}));

  // R7
  cfg_bad_no_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgBad |-> !bankWrEn);

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R9
  busy_while_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid || bankWrEn || cfgDone || cfgBad) |-> !reqReady);

  // R4
  one_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspValid, cfgDone, cfgBad}));

endmodule

bind bank_window_xlate bank_window_xlate_chk #(.BANK_W(BANK_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .rspValid  (rspValid),
  .bankWrEn  (bankWrEn),
  .bankWrData(bankWrData),
  .cfgDone   (cfgDone),
  .cfgBad    (cfgBad)
);

// File: tb/bank_window_xlate_tb.sv
`timescale 1ns/1ps
module bank_window_xlate_tb;

  localparam int ADDR_W = 20;
  localparam int WOFF   = 13;
  localparam int BANK_W = ADDR_W - WOFF;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgValid = 1'b0;
  logic [19:0]       cfgBase = '0;
  logic              cfgDone, cfgBad;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqBase = '0;
  logic [15:0]       reqOffset = '0;
  logic              rspValid;
  logic [WOFF-1:0]   rspOffset;
  logic              rspAlignErr;
  logic              bankWrEn;
  logic [BANK_W:0]   bankWrData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of the mapped bank
  logic [BANK_W-1:0] mBank = '0;
  bit                mValid = 1'b0;

  always #2.5 clk = ~clk;

  bank_window_xlate u_dut (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgBase(cfgBase), .cfgDone(cfgDone), .cfgBad(cfgBad),
    .reqValid(reqValid), .reqReady(reqReady), .reqBase(reqBase), .reqOffset(reqOffset),
    .rspValid(rspValid), .rspOffset(rspOffset), .rspAlignErr(rspAlignErr),
    .bankWrEn(bankWrEn), .bankWrData(bankWrData)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // request; drives and samples on falling edges
  task automatic doReq(input string tag, input logic [ADDR_W-1:0] base, input logic [15:0] off);
    logic [ADDR_W-1:0] lin;
    logic [BANK_W-1:0] bank;
    logic [WOFF-1:0]   woff;
    bit                miss;
    lin  = base + ADDR_W'({off, 1'b0});
    bank = lin[ADDR_W-1:WOFF];
    woff = lin[WOFF-1:0];
    miss = !mValid || (mBank != bank);
    @(negedge clk);
    check({tag, " R9 ready idle"}, reqReady, 1);
    reqValid = 1'b1; reqBase = base; reqOffset = off;
    @(negedge clk);
    reqValid = 1'b0; reqBase = '0; reqOffset = '0;
    check({tag, " R9 busy"}, reqReady, 0);
    if (miss) begin
      check({tag, " R4 miss write"}, bankWrEn, 1);
      check({tag, " R2 write data"}, bankWrData, {1'b1, bank});
      check({tag, " R4 no early rsp"}, rspValid, 0);
      mBank = bank; mValid = 1'b1;
      @(negedge clk);
      check({tag, " R4 write one cycle"}, bankWrEn, 0);
    end else begin
      check({tag, " R4 hit no write"}, bankWrEn, 0);
    end
    check({tag, " R4 rsp"}, rspValid, 1);
    check({tag, " R3 offset"}, rspOffset, woff);
    check({tag, " R8 align"}, rspAlignErr, woff[0]);
    @(negedge clk);
    check({tag, " R4 rsp pulse"}, rspValid, 0);
  endtask

  task automatic doCfg(input string tag, input logic [19:0] base, input bit expOk);
    @(negedge clk);
    cfgValid = 1'b1; cfgBase = base; reqValid = 1'b1; reqBase = 20'h12345;
    #0.1;
    check({tag, " R9 cfg priority"}, reqReady, 0);
    @(negedge clk);
    cfgValid = 1'b0; cfgBase = '0; reqValid = 1'b0; reqBase = '0;
    if (expOk) begin
      check({tag, " R6 done"}, cfgDone, 1);
      check({tag, " R6 bank0 write"}, bankWrEn, 1);
      check({tag, " R6 write data"}, bankWrData, {1'b1, {BANK_W{1'b0}}});
      mBank = '0; mValid = 1'b1;
    end else begin
      check({tag, " R7 bad"}, cfgBad, 1);
      check({tag, " R7 no write"}, bankWrEn, 0);
      check({tag, " R7 not done"}, cfgDone, 0);
    end
    check({tag, " R9 no request taken"}, rspValid, 0);
    @(negedge clk);
    check({tag, " R6 R7 pulse ends"}, cfgDone | cfgBad | bankWrEn, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R10 ready", reqReady, 1);
    check("R10 rsp", rspValid, 0);
    check("R10 wr", bankWrEn, 0);
    check("R10 cfg", cfgDone | cfgBad, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    doReq("R5 first access bank0", 20'h00000, 16'h0000);
    doReq("R3 hit", 20'h00000, 16'h0010);
    doReq("R1 cross bank", 20'h01FF0, 16'h0010);
    doReq("R1 wrap", 20'hFFFFE, 16'h0002);
    doReq("R8 odd", 20'h02001, 16'h0003);
    doReq("R2 high bank", 20'h80000, 16'hFFFF);
    doReq("R4 same bank", 20'h9E000, 16'h0100);
    doCfg("R6 accept", 20'hDE000, 1'b1);
    doReq("R6 bank0 hit", 20'h00000, 16'h0004);
    doReq("R4 leave bank0", 20'h04000, 16'h0000);
    doCfg("R6 accept plain", 20'hC0000, 1'b1);
    doCfg("R7 reject bit12", 20'hC1000, 1'b0);
    doCfg("R7 reject high", 20'hA0000, 1'b0);
    doReq("R7 bank kept", 20'h00100, 16'h0001);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule